// File: doc/BRIEF.md
# I2C Byte Shifter with Acknowledge Slot

This block moves one I2C byte and its acknowledge bit across the SDA line in both directions. A separate clock generator supplies single-cycle strobes that mark each SCL rise and fall. A load pulse captures a 9-bit transmit word. The block then drives the eight data bits most significant first, followed by the acknowledge bit. SDA is open-drain, so the block only ever asks to pull the line low. Each output change can be held back by a selectable number of cycles, which gives the hold time after the clock falls.

The same nine SCL rises sample the line to build a 9-bit receive word. Two bit layouts are available. The plain layout puts the byte in the low eight bits. The address layout puts the first seven bits in the low bits, so a 7-bit address can be read directly, and moves the eighth bit to the top. While the interface is disabled, SDA takes a programmable idle level. A released bit that reads back low marks lost arbitration.

Top module: `i2c_byte_shifter`

## Requirements
- R1: After reset, with `en` low and `idle_hi` high, `sda_drive_low`, `done` and `arb_lost` are 0 and `rx_word` is 0.
- R2: After a load pulse while enabled and not busy, the line carries `tx_word` bits 7 down to 0 and then bit 8. The block advances one bit on each `scl_fall` strobe, and a bit value of 1 means the line is released.
- R3: With `dly_sel` = 0, SDA changes take effect in the same cycle. With `dly_sel` = k (1..7), the line value is the one requested k+1 clock cycles earlier.
- R4: While `sda_off` is high, `sda_drive_low` is 0 whatever the shift state.
- R5: While `en` is low, the requested line level is `idle_hi`, passed through the same delay. Clearing `en` also abandons any byte in progress.
- R6: In the plain layout (`rx_addr_layout` = 0), the k-th sampled bit (k = 0..7) lands in `rx_word` bit 7-k, and the ninth sample lands in bit 8.
- R7: In the address layout (`rx_addr_layout` = 1, `ckph` = 0), the k-th sample (k = 0..6) lands in bit 6-k, the eighth sample lands in bit 8 and the ninth sample lands in bit 7.
- R8: When `rx_addr_layout` = 1 and `ckph` = 1, the plain layout of R6 is used.
- R9: `rx_word` changes only in the cycle after the ninth `scl_rise` strobe of a byte. `done` is high for exactly that one cycle.
- R10: With `arb_en` high, if one of the first eight bits is released but the line samples low on a rise strobe, `arb_lost` goes high and the line stays released for the rest of the byte. `arb_lost` is cleared by the next accepted load or by `en` low.
- R11: A load pulse while a byte is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the count source for the delay |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Interface enable |
| load | input | 1 | Start a byte with `tx_word` |
| tx_word | input | 9 | Bits 7..0 data (MSB first), bit 8 acknowledge |
| scl_rise | input | 1 | SCL rising-edge strobe |
| scl_fall | input | 1 | SCL falling-edge strobe |
| sda_in | input | 1 | Sampled SDA line level |
| arb_en | input | 1 | Enable arbitration-loss detection |
| dly_sel | input | 3 | Output delay select (0 = none, k = k+1 cycles) |
| sda_off | input | 1 | Force SDA released (high impedance) |
| rx_addr_layout | input | 1 | Receive layout select (1 = address layout) |
| ckph | input | 1 | Clock-phase option; forces plain layout |
| idle_hi | input | 1 | SDA level while disabled |
| sda_drive_low | output | 1 | Open-drain pull-down enable for SDA |
| rx_word | output | 9 | Arranged receive word |
| done | output | 1 | One-cycle pulse after the ninth rise |
| arb_lost | output | 1 | Arbitration lost during the current byte |

## Verification
A bit counter that is out of step shows up on `sda_drive_low` within one delay window of the next fall strobe. The same fault shows up at the ninth rise as a missing or early `done` and a misplaced `rx_word`. A wrong delay tap shows as the line changing in the wrong cycle on the first transition after `dly_sel` is set. A lost or stuck arbitration flag shows within one bit time, because the line is then pulled low where a release is expected, or released where a pull is expected. A wrong layout mapping is visible only on `rx_word`, in the cycle `done` rises.

// File: rtl/isb_pkg.sv
package isb_pkg;
  typedef enum logic {
    LAYOUT_PLAIN = 1'b0,
    LAYOUT_ADDR  = 1'b1
  } rx_layout_e;
endpackage

// File: rtl/isb_reset_sync.sv
module isb_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/isb_delay_line.sv
module isb_delay_line #(
  parameter int unsigned MAX_DLY = 8,
  localparam int unsigned SEL_W  = $clog2(MAX_DLY)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  output logic             dout
);
  logic [MAX_DLY-1:0] stg_q, stg_d;

  always_comb stg_d = {stg_q[MAX_DLY-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '1;
    else        stg_q <= stg_d;
  end

  // tap k holds the value from k+1 cycles back
  assign dout = (sel == '0) ? din : stg_q[sel];
endmodule

// File: rtl/isb_rx_arrange.sv
module isb_rx_arrange
  import isb_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = BYTE_W + 1
) (
  input  logic [WORD_W-1:0] samples,  // bit k = k-th sample
  input  rx_layout_e        layout,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] plain_w, addr_w;

  for (genvar k = 0; k < BYTE_W; k++) begin : g_plain
    assign plain_w[BYTE_W-1-k] = samples[k];
  end
  assign plain_w[BYTE_W] = samples[BYTE_W];

  for (genvar k = 0; k < BYTE_W-1; k++) begin : g_addr
    assign addr_w[BYTE_W-2-k] = samples[k];
  end
  assign addr_w[BYTE_W]   = samples[BYTE_W-1];
  assign addr_w[BYTE_W-1] = samples[BYTE_W];

  assign word = (layout == LAYOUT_ADDR) ? addr_w : plain_w;
endmodule

// File: rtl/isb_shift_ctrl.sv
module isb_shift_ctrl #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = BYTE_W + 1,
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_in,
  input  logic              arb_en,
  input  logic              idle_hi,
  input  logic [WORD_W-1:0] arranged,
  output logic [WORD_W-1:0] samples,
  output logic              line_req,
  output logic [WORD_W-1:0] rx_word,
  output logic              done,
  output logic              arb_lost
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] seq_q, seq_d;
  logic [BYTE_W-1:0] samp_q, samp_d;
  logic              arb_q, arb_d;
  logic              done_q, done_d;
  logic [WORD_W-1:0] rxw_q, rxw_d;
  logic              last_bit, cur_bit;

  assign last_bit = (cnt_q == LAST);
  assign cur_bit  = seq_q[WORD_W-1];
  assign samples  = {sda_in, samp_q};

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    seq_d  = seq_q;
    samp_d = samp_q;
    arb_d  = arb_q;
    done_d = 1'b0;
    rxw_d  = rxw_q;
    if (!en) begin
      busy_d = 1'b0;
      cnt_d  = '0;
      arb_d  = 1'b0;
    end else if (load && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      arb_d  = 1'b0;
      seq_d  = {tx_word[BYTE_W-1:0], tx_word[BYTE_W]};
    end else if (busy_q && scl_rise) begin
      if (arb_en && !last_bit && cur_bit && !sda_in) arb_d = 1'b1;
      for (int i = 0; i < BYTE_W; i++) begin
        if (cnt_q == CNT_W'(i)) samp_d[i] = sda_in;
      end
      if (last_bit) begin
        done_d = 1'b1;
        busy_d = 1'b0;
        rxw_d  = arranged;
      end
    end else if (busy_q && scl_fall && !last_bit) begin
      cnt_d = cnt_q + CNT_W'(1);
      seq_d = {seq_q[WORD_W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      seq_q  <= '1;
      samp_q <= '0;
      arb_q  <= 1'b0;
      done_q <= 1'b0;
      rxw_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      seq_q  <= seq_d;
      samp_q <= samp_d;
      arb_q  <= arb_d;
      done_q <= done_d;
      rxw_q  <= rxw_d;
    end
  end

  always_comb begin
    if (!en)                  line_req = idle_hi;
    else if (busy_q && !arb_q) line_req = cur_bit;
    else                      line_req = 1'b1;
  end

  assign rx_word  = rxw_q;
  assign done     = done_q;
  assign arb_lost = arb_q;
endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter
  import isb_pkg::*;
#(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned MAX_DLY = 8,
  localparam int unsigned SEL_W  = $clog2(MAX_DLY)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load,
  input  logic [BYTE_W:0]   tx_word,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_in,
  input  logic              arb_en,
  input  logic [SEL_W-1:0]  dly_sel,
  input  logic              sda_off,
  input  logic              rx_addr_layout,
  input  logic              ckph,
  input  logic              idle_hi,
  output logic              sda_drive_low,
  output logic [BYTE_W:0]   rx_word,
  output logic              done,
  output logic              arb_lost
);
  logic            rst_n_sync;
  logic            line_req, line_dly;
  logic [BYTE_W:0] samples, arranged;
  rx_layout_e      layout;

  assign layout = (rx_addr_layout && !ckph) ? LAYOUT_ADDR : LAYOUT_PLAIN;

  isb_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  isb_shift_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .en       (en),
    .load     (load),
    .tx_word  (tx_word),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_in   (sda_in),
    .arb_en   (arb_en),
    .idle_hi  (idle_hi),
    .arranged (arranged),
    .samples  (samples),
    .line_req (line_req),
    .rx_word  (rx_word),
    .done     (done),
    .arb_lost (arb_lost)
  );

  isb_rx_arrange #(.BYTE_W(BYTE_W)) u_arr (
    .samples (samples),
    .layout  (layout),
    .word    (arranged)
  );

  isb_delay_line #(.MAX_DLY(MAX_DLY)) u_dly (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .din   (line_req),
    .sel   (dly_sel),
    .dout  (line_dly)
  );

  assign sda_drive_low = !sda_off && !line_dly;
endmodule

// File: rtl/isb_checker.sv
module isb_checker #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned SEL_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             load,
  input logic             sda_off,
  input logic             idle_hi,
  input logic [SEL_W-1:0] dly_sel,
  input logic             sda_drive_low,
  input logic [BYTE_W:0]  rx_word,
  input logic             done,
  input logic             arb_lost
);
  // R4
  force_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_off |-> !sda_drive_low);

  // R5
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !sda_off && dly_sel == '0) |-> (sda_drive_low == !idle_hi));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rx_word));

  // R10
  arb_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && arb_lost && !load) |=> arb_lost);
endmodule

bind i2c_byte_shifter isb_checker #(.BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_isb_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .en            (en),
  .load          (load),
  .sda_off       (sda_off),
  .idle_hi       (idle_hi),
  .dly_sel       (dly_sel),
  .sda_drive_low (sda_drive_low),
  .rx_word       (rx_word),
  .done          (done),
  .arb_lost      (arb_lost)
);

// File: tb/test_i2c_byte_shifter.sv
`timescale 1ns/1ps
module test_i2c_byte_shifter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, load = 1'b0, scl_rise = 1'b0, scl_fall = 1'b0;
  logic [8:0] tx_word = 9'h000;
  logic       arb_en = 1'b0, sda_off = 1'b0, rx_addr_layout = 1'b0, ckph = 1'b0;
  logic       idle_hi = 1'b1;
  logic [2:0] dly_sel = 3'd0;
  logic       slave_low = 1'b0;
  logic       sda_in;
  logic       sda_drive_low, done, arb_lost;
  logic [8:0] rx_word;

  int n_chk = 0, n_fail = 0, cyc = 0, done_seen = 0;
  bit chk_on = 1'b0;

  always #4 clk = ~clk;

  assign sda_in = !sda_drive_low && !slave_low;

  i2c_byte_shifter i_i2c_byte_shifter (
    .clk(clk), .rst_n(rst_n), .en(en), .load(load), .tx_word(tx_word),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in), .arb_en(arb_en),
    .dly_sel(dly_sel), .sda_off(sda_off), .rx_addr_layout(rx_addr_layout),
    .ckph(ckph), .idle_hi(idle_hi), .sda_drive_low(sda_drive_low),
    .rx_word(rx_word), .done(done), .arb_lost(arb_lost)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // input snapshot taken after inputs settle, used by the model
  bit s_en = 0, s_load = 0, s_rise = 0, s_fall = 0, s_sda = 1, s_arb_en = 0;
  bit s_off = 0, s_lay = 0, s_ckph = 0, s_idle = 1;
  int s_sel = 0;
  int s_tx = 0;
  always @(negedge clk) begin
    #3;
    s_en = en; s_load = load; s_rise = scl_rise; s_fall = scl_fall; s_sda = sda_in;
    s_arb_en = arb_en; s_off = sda_off; s_lay = rx_addr_layout; s_ckph = ckph;
    s_idle = idle_hi; s_sel = int'(dly_sel); s_tx = int'(tx_word);
  end

  // behavioural reference
  bit m_busy = 0, m_arb = 0, m_done = 0;
  int m_cnt = 0, m_tx = 0, m_rx = 0;
  bit m_s[9];
  bit hist[$] = '{1, 1, 1, 1, 1, 1, 1, 1, 1};

  function automatic bit m_bit();
    return (m_cnt < 8) ? m_tx[7 - m_cnt] : m_tx[8];
  endfunction

  function automatic bit m_target();
    if (!s_en) return s_idle;
    if (m_busy && !m_arb) return m_bit();
    return 1'b1;
  endfunction

  function automatic bit m_drive();
    bit v;
    v = (s_sel == 0) ? m_target() : hist[s_sel];
    return !s_off && !v;
  endfunction

  function automatic int m_arrange();
    int w = 0;
    if (s_lay && !s_ckph) begin
      for (int k = 0; k < 7; k++) w += int'(m_s[k]) << (6 - k);
      w += int'(m_s[7]) << 8;
      w += int'(m_s[8]) << 7;
    end else begin
      for (int k = 0; k < 8; k++) w += int'(m_s[k]) << (7 - k);
      w += int'(m_s[8]) << 8;
    end
    return w;
  endfunction

  always @(posedge clk) begin
    hist.push_front(m_target());
    if (hist.size() > 9) void'(hist.pop_back());
    m_done = 0;
    if (!s_en) begin
      m_busy = 0; m_cnt = 0; m_arb = 0;
    end else if (s_load && !m_busy) begin
      m_busy = 1; m_cnt = 0; m_arb = 0; m_tx = s_tx;
    end else if (m_busy && s_rise) begin
      if (s_arb_en && m_cnt < 8 && m_bit() && !s_sda) m_arb = 1;
      m_s[m_cnt] = s_sda;
      if (m_cnt == 8) begin
        m_done = 1; m_busy = 0; m_rx = m_arrange();
      end
    end else if (m_busy && s_fall && m_cnt < 8) begin
      m_cnt++;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (done) done_seen++;
    if (chk_on) begin
      chk("R2 R3 R4 R5 sda_drive_low", int'(sda_drive_low), int'(m_drive()));
      chk("R9 done", int'(done), int'(m_done));
      chk("R10 arb_lost", int'(arb_lost), int'(m_arb));
      chk("R6 R7 R8 R9 rx_word", int'(rx_word), m_rx);
    end
    if (cyc > 100000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic run_byte(input logic [8:0] tx, input logic [8:0] pull, input bit inject);
    tx_word = tx; load = 1'b1;
    step(1);
    load = 1'b0;
    for (int b = 0; b < 9; b++) begin
      slave_low = pull[b];
      step(10);
      scl_rise = 1'b1;
      step(1);
      scl_rise = 1'b0;
      if (inject && b == 4) begin tx_word = 9'h000; load = 1'b1; end
      step(1);
      load = 1'b0;
      step(3);
      if (b < 8) begin scl_fall = 1'b1; step(1); scl_fall = 1'b0; end
    end
    slave_low = 1'b0;
    step(3);
  endtask

  initial begin
    int d0;
    step(3);
    rst_n = 1'b1;
    step(4);
    // R1 reset state
    chk("R1 sda_drive_low", int'(sda_drive_low), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 arb_lost", int'(arb_lost), 0);
    chk("R1 rx_word", int'(rx_word), 0);
    chk_on = 1'b1;

    // R5 idle level, R3 delay of 5 cycles with dly_sel=4
    dly_sel = 3'd4;
    idle_hi = 1'b0;
    repeat (4) @(negedge clk);
    chk("R3 before tap", int'(sda_drive_low), 0);
    @(negedge clk);
    chk("R3 at tap R5", int'(sda_drive_low), 1);
    #1;
    idle_hi = 1'b1; dly_sel = 3'd0;
    step(10);
    chk("R5 idle released", int'(sda_drive_low), 0);

    // R2 R6 plain layout, slave acks
    en = 1'b1;
    step(2);
    d0 = done_seen;
    run_byte(9'h1A5, 9'h100, 1'b0);
    chk("R6 plain rx", int'(rx_word), 9'h0A5);
    chk("R9 one done", done_seen - d0, 1);

    // R7 address layout, delay 2 cycles
    rx_addr_layout = 1'b1; dly_sel = 3'd1;
    run_byte(9'h1A5, 9'h100, 1'b0);
    chk("R7 addr rx", int'(rx_word), 9'h152);

    // R8 clock-phase forces plain, delay 8 cycles
    ckph = 1'b1; dly_sel = 3'd7;
    run_byte(9'h1A5, 9'h100, 1'b0);
    chk("R8 ckph rx", int'(rx_word), 9'h0A5);

    // receive 0x3C, master acks, both layouts; R11 load mid-byte ignored
    ckph = 1'b0; dly_sel = 3'd0; rx_addr_layout = 1'b0;
    run_byte(9'h0FF, 9'h0C3, 1'b1);
    chk("R11 R6 receive rx", int'(rx_word), 9'h03C);
    rx_addr_layout = 1'b1;
    run_byte(9'h0FF, 9'h0C3, 1'b0);
    chk("R7 receive rx", int'(rx_word), 9'h01E);

    // R10 arbitration lost at bit 2
    rx_addr_layout = 1'b0; arb_en = 1'b1; dly_sel = 3'd2;
    run_byte(9'h1FF, 9'h004, 1'b0);
    chk("R10 arb set", int'(arb_lost), 1);
    chk("R10 arb rx", int'(rx_word), 9'h1DF);
    tx_word = 9'h000; load = 1'b1;
    step(1);
    load = 1'b0;
    chk("R10 arb cleared", int'(arb_lost), 0);
    // R4 forced release while driving zeros
    sda_off = 1'b1;
    step(12);
    chk("R4 forced release", int'(sda_drive_low), 0);
    sda_off = 1'b0;
    step(12);
    chk("R2 drives zero", int'(sda_drive_low), 1);
    en = 1'b0;
    step(12);
    chk("R5 abandon byte", int'(sda_drive_low), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule